// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs the external memory bus of a small 8-bit controller core. It splits the oscillator clock into 12-clock machine cycles, each made of two 6-clock halves. At the end of every machine cycle it can accept one request from the core: a code fetch at a 16-bit program counter, or a data read or write. A data request uses either a 16-bit pointer or an 8-bit indirect address. During the following machine cycle it produces the address latch strobe, the code-read enable and the data read and write strobes. It also drives the multiplexed low address/data byte and the high byte, and it captures the returned byte.

Code fetches go to a synchronous on-chip ROM port when the internal-code input is high and the address is at or below 1FFFh. All other fetches, and every data access, go to the external bus. When the bus is not in use, the two ports follow their port registers. The low port behaves as open drain and the high port as quasi-bidirectional. Only logical pin values and output enables are produced.

Top module: `xbus_seq`

## Requirements
- R1: The latch strobe `ale` is high during phases 0, 1, 6 and 7 of every 12-clock machine cycle and low in the other phases, whether or not a request is active. Phase 0 is the first clock after the edge that accepts a request, and also the first clock after reset is released.
- R2: During a data read or write cycle the second latch pulse (phases 6–7) is dropped, while the first (phases 0–1) still appears.
- R3: When `int_code_en`=0 every fetch is external. When it is 1, a fetch at an address ≤ 1FFFh is internal and an address above 1FFFh is external. An internal fetch asserts `rom_en` in phase 0 with `rom_addr` equal to the fetch address, and it leaves both ports and all strobes idle.
- R4: `psen_n` is low in phases 3–5 of an external fetch and high at all other times, including internal fetches and data cycles.
- R5: `rd_n` (read) or `wr_n` (write) is low in phases 6–11 of a data cycle and high otherwise. No two of `psen_n`, `rd_n` and `wr_n` are ever low together.
- R6: During an external access the low port drives the low address byte with `lo_oe`=FFh. It does so in phases 0–2 of a fetch and phases 0–5 of a data cycle. A write drives the write data in phases 6–11. In all other phases of the access `lo_oe`=00h.
- R7: During an external access `hi_oe`=FFh and `hi_out` is the high address byte for fetches and for pointer accesses (`req_wide`=1). For indirect accesses (`req_wide`=0) `hi_out` is the value of `p2_sfr`.
- R8: Outside external accesses `lo_out`=`p0_sfr` with `lo_oe`=~`p0_sfr`, and `hi_out`=`p2_sfr` with `hi_oe`=~`p2_sfr`.
- R9: `rsp_valid` pulses for one clock in phase 0 after a fetch or read cycle, and stays low after a write. `rsp_data` carries the sampled byte: `lo_in` in phase 5 of an external fetch, `rom_rdata` in phase 1 of an internal fetch, or `lo_in` in phase 11 of a read.
- R10: `req_ready` is high only in phase 11, and a request is taken at the clock edge that ends it. `req_op` codes are 0 fetch, 1 read, 2 write; code 3 is treated as no request.
- R11: While `rst_n` is low the sequencer sits in phase 0 with all three strobes high and no access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_code_en | input | 1 | Permits internal code fetches at or below 1FFFh |
| req_valid | input | 1 | Core request present |
| req_op | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| req_wide | input | 1 | Data access uses a 16-bit pointer |
| req_addr | input | 16 | Fetch or data address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request is accepted at the next edge |
| rsp_valid | output | 1 | Returned byte valid |
| rsp_data | output | 8 | Returned byte |
| rom_en | output | 1 | On-chip ROM read enable |
| rom_addr | output | 16 | On-chip ROM address |
| rom_rdata | input | 8 | On-chip ROM data, one clock after enable |
| p0_sfr | input | 8 | Low port register value |
| p2_sfr | input | 8 | High port register value |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | External code read enable, active low |
| rd_n | output | 1 | External data read strobe, active low |
| wr_n | output | 1 | External data write strobe, active low |
| lo_out | output | 8 | Low port output value |
| lo_oe | output | 8 | Low port output enable per bit |
| lo_in | input | 8 | Low port pin value |
| hi_out | output | 8 | High port output value |
| hi_oe | output | 8 | High port output enable per bit |

## Verification
On every cycle the assertions check the following. Latch strobe edges fall only on phase 0 or 6, and the latch strobe is silent while a data strobe is low. The three strobes are mutually exclusive. The low port floats while the code-read enable is low and is driven throughout a write strobe. Responses appear only in phase 0. The bench scenarios are needed to show the rest: which address bytes and register values reach the ports in each phase, and that the internal/external split follows the 1FFFh boundary. They also show that the returned byte is the one present at the correct sampling clock, and that indirect accesses put the port register value on the high byte.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    OP_FETCH = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;
endpackage

// File: rtl/xbus_phase.sv
module xbus_phase #(
  parameter int HALF  = 6,
  parameter int ALE_W = 2,
  localparam int CYC = 2 * HALF,
  localparam int PW  = $clog2(CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          cyc_last,
  output logic          second_half,
  output logic          ale_slot
);
  localparam logic [PW-1:0] LAST_P = PW'(CYC - 1);
  localparam logic [PW-1:0] HALF_P = PW'(HALF);
  localparam logic [PW-1:0] ALEW_P = PW'(ALE_W);
  localparam logic [PW-1:0] ALE2_P = PW'(HALF + ALE_W);

  logic [PW-1:0] phase_n;

  always_comb begin
    phase_n = (phase == LAST_P) ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_n;
  end

  assign cyc_last    = (phase == LAST_P);
  assign second_half = (phase >= HALF_P);
  assign ale_slot    = (phase < ALEW_P) || (phase >= HALF_P && phase < ALE2_P);

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_last) |-> (phase == '0));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int HALF = 6,
  parameter logic [AW-1:0] INT_TOP = 16'h1FFF,
  localparam int CYC = 2 * HALF,
  localparam int PW  = $clog2(CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase,
  input  logic          cyc_last,
  input  logic          second_half,
  input  logic          ale_slot,
  input  logic          int_code_en,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] rom_rdata,
  input  logic [DW-1:0] lo_in,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          rom_en,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          bus_active,
  output logic          drv_addr,
  output logic          drv_wdata,
  output logic          hi_use_sfr,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_wdata
);
  localparam logic [PW-1:0] ADR_P  = PW'(HALF / 2);
  localparam logic [PW-1:0] HALF_P = PW'(HALF);
  localparam logic [PW-1:0] FSMP_P = PW'(HALF - 1);
  localparam logic [PW-1:0] RSMP_P = PW'(CYC - 1);
  localparam logic [PW-1:0] ROMS_P = PW'(1);

  logic          cur_val, cur_val_n;
  op_e           cur_op, cur_op_n;
  logic          cur_wide, cur_wide_n;
  logic          cur_ext, cur_ext_n;
  logic [AW-1:0] cur_addr_n;
  logic [DW-1:0] cur_wdata_n;
  logic          rsp_valid_n;
  logic [DW-1:0] rsp_data_n;
  logic          is_fetch, is_data, ext_fetch, int_fetch, smp;

  assign is_fetch  = cur_val && (cur_op == OP_FETCH);
  assign is_data   = cur_val && (cur_op == OP_READ || cur_op == OP_WRITE);
  assign ext_fetch = is_fetch && cur_ext;
  assign int_fetch = is_fetch && !cur_ext;

  assign smp = (ext_fetch && phase == FSMP_P) ||
               (int_fetch && phase == ROMS_P) ||
               (is_data && cur_op == OP_READ && phase == RSMP_P);

  always_comb begin
    cur_val_n   = cur_val;
    cur_op_n    = cur_op;
    cur_wide_n  = cur_wide;
    cur_ext_n   = cur_ext;
    cur_addr_n  = cur_addr;
    cur_wdata_n = cur_wdata;
    rsp_valid_n = 1'b0;
    rsp_data_n  = rsp_data;
    if (smp) rsp_data_n = int_fetch ? rom_rdata : lo_in;
    if (cyc_last) begin
      rsp_valid_n = cur_val && (cur_op != OP_WRITE);
      cur_val_n   = req_valid && (req_op != OP_NONE);
      cur_op_n    = op_e'(req_op);
      cur_wide_n  = req_wide;
      cur_addr_n  = req_addr;
      cur_wdata_n = req_wdata;
      cur_ext_n   = (req_op != OP_FETCH) || !int_code_en || (req_addr > INT_TOP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_val   <= 1'b0;
      cur_op    <= OP_NONE;
      cur_wide  <= 1'b0;
      cur_ext   <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      cur_val   <= cur_val_n;
      cur_op    <= cur_op_n;
      cur_wide  <= cur_wide_n;
      cur_ext   <= cur_ext_n;
      cur_addr  <= cur_addr_n;
      cur_wdata <= cur_wdata_n;
      rsp_valid <= rsp_valid_n;
      rsp_data  <= rsp_data_n;
    end
  end

  assign ale        = ale_slot && !(is_data && second_half);
  assign psen_n     = !(ext_fetch && phase >= ADR_P && phase < HALF_P);
  assign rd_n       = !(is_data && cur_op == OP_READ && second_half);
  assign wr_n       = !(is_data && cur_op == OP_WRITE && second_half);
  assign rom_en     = int_fetch && (phase == '0);
  assign bus_active = ext_fetch || is_data;
  assign drv_addr   = (ext_fetch && phase < ADR_P) || (is_data && !second_half);
  assign drv_wdata  = is_data && cur_op == OP_WRITE && second_half;
  assign hi_use_sfr = is_data && !cur_wide;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  // R2
  ale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !ale);
  // R9
  rsp_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (phase == '0));
endmodule

// File: rtl/xbus_pads.sv
module xbus_pads #(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          bus_active,
  input  logic          drv_addr,
  input  logic          drv_wdata,
  input  logic          hi_use_sfr,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] cur_wdata,
  input  logic [DW-1:0] p0_sfr,
  input  logic [HW-1:0] p2_sfr,
  output logic [DW-1:0] lo_out,
  output logic [DW-1:0] lo_oe,
  output logic [HW-1:0] hi_out,
  output logic [HW-1:0] hi_oe
);
  always_comb begin
    if (drv_addr) begin
      lo_out = cur_addr[DW-1:0];
      lo_oe  = '1;
    end else if (drv_wdata) begin
      lo_out = cur_wdata;
      lo_oe  = '1;
    end else if (bus_active) begin
      lo_out = '1;
      lo_oe  = '0;
    end else begin
      lo_out = p0_sfr;
      lo_oe  = ~p0_sfr;
    end
    if (bus_active) begin
      hi_out = hi_use_sfr ? p2_sfr : cur_addr[AW-1:DW];
      hi_oe  = '1;
    end else begin
      hi_out = p2_sfr;
      hi_oe  = ~p2_sfr;
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int HALF = 6,
  parameter int ALE_W = 2,
  parameter logic [AW-1:0] INT_TOP = 16'h1FFF,
  localparam int HW = AW - DW,
  localparam int PW = $clog2(2 * HALF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_code_en,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rom_en,
  output logic [AW-1:0] rom_addr,
  input  logic [DW-1:0] rom_rdata,
  input  logic [DW-1:0] p0_sfr,
  input  logic [HW-1:0] p2_sfr,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] lo_out,
  output logic [DW-1:0] lo_oe,
  input  logic [DW-1:0] lo_in,
  output logic [HW-1:0] hi_out,
  output logic [HW-1:0] hi_oe
);
  localparam logic [PW-1:0] HALF_P = PW'(HALF);

  logic [PW-1:0] phase;
  logic          cyc_last, second_half, ale_slot;
  logic          bus_active, drv_addr, drv_wdata, hi_use_sfr;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;

  xbus_phase #(.HALF(HALF), .ALE_W(ALE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cyc_last(cyc_last),
    .second_half(second_half), .ale_slot(ale_slot)
  );

  xbus_ctrl #(.AW(AW), .DW(DW), .HALF(HALF), .INT_TOP(INT_TOP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cyc_last(cyc_last),
    .second_half(second_half), .ale_slot(ale_slot), .int_code_en(int_code_en),
    .req_valid(req_valid), .req_op(req_op), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .rom_rdata(rom_rdata),
    .lo_in(lo_in), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .rom_en(rom_en), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_active(bus_active), .drv_addr(drv_addr), .drv_wdata(drv_wdata),
    .hi_use_sfr(hi_use_sfr), .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  xbus_pads #(.AW(AW), .DW(DW)) u_pads (
    .bus_active(bus_active), .drv_addr(drv_addr), .drv_wdata(drv_wdata),
    .hi_use_sfr(hi_use_sfr), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .p0_sfr(p0_sfr), .p2_sfr(p2_sfr), .lo_out(lo_out), .lo_oe(lo_oe),
    .hi_out(hi_out), .hi_oe(hi_oe)
  );

  assign req_ready = cyc_last;
  assign rom_addr  = cur_addr;

  // R1
  ale_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> (phase == '0 || phase == HALF_P));
  // R4
  psen_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (lo_oe == '0));
  // R6
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (lo_oe == '1));
  // R11
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!rst_n |-> (psen_n && rd_n && wr_n)));
endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        int_code_en;
  logic        req_valid;
  logic [1:0]  req_op;
  logic        req_wide;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_valid, rom_en, ale, psen_n, rd_n, wr_n;
  logic [7:0]  rsp_data, rom_rdata, p0_sfr, p2_sfr, lo_out, lo_oe, lo_in, hi_out, hi_oe;
  logic [15:0] rom_addr;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  xbus_seq dut (
    .clk(clk), .rst_n(rst_n), .int_code_en(int_code_en), .req_valid(req_valid),
    .req_op(req_op), .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .p0_sfr(p0_sfr), .p2_sfr(p2_sfr), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in),
    .hi_out(hi_out), .hi_oe(hi_oe)
  );

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (rom_en) rom_rdata <= rom_fn(rom_addr);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic wide,
                        input logic [15:0] addr, input logic [7:0] wd, input logic ie);
    logic isf, isd, ext, intf, da, dw, eale;
    logic [7:0] din, ehi, elo_oe;
    isf  = (op == 2'd0);
    isd  = (op == 2'd1 || op == 2'd2);
    ext  = isd || (isf && (!ie || addr > 16'h1FFF));
    intf = isf && !ext;
    din  = 8'($urandom);
    int_code_en = ie;
    req_valid = 1'b1; req_op = op; req_wide = wide; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    chk(req_ready, "R10 ready in phase 11", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0; req_addr = 16'($urandom); req_wdata = 8'($urandom);
    int_code_en = 1'($urandom);
    lo_in = din;
    for (int k = 0; k < 12; k++) begin
      eale = ((k % 6) < 2) && !(isd && k >= 6);
      chk(ale == eale, isd ? "R2 ale drop" : "R1 ale rate", int'(ale), int'(eale));
      chk(psen_n == !(isf && ext && k >= 3 && k < 6), "R4 psen_n", int'(psen_n),
          int'(!(isf && ext && k >= 3 && k < 6)));
      chk(rd_n == !(op == 2'd1 && k >= 6), "R5 rd_n", int'(rd_n), int'(!(op == 2'd1 && k >= 6)));
      chk(wr_n == !(op == 2'd2 && k >= 6), "R5 wr_n", int'(wr_n), int'(!(op == 2'd2 && k >= 6)));
      da = ext && ((isf && k < 3) || (isd && k < 6));
      dw = (op == 2'd2) && k >= 6;
      elo_oe = (da || dw) ? 8'hFF : ext ? 8'h00 : ~p0_sfr;
      chk(lo_oe == elo_oe, ext ? "R6 lo_oe" : "R8 lo_oe", int'(lo_oe), int'(elo_oe));
      if (da) chk(lo_out == addr[7:0], "R6 lo addr", int'(lo_out), int'(addr[7:0]));
      else if (dw) chk(lo_out == wd, "R6 lo wdata", int'(lo_out), int'(wd));
      else if (!ext) chk(lo_out == p0_sfr, "R8 lo idle", int'(lo_out), int'(p0_sfr));
      ehi = ext ? ((isd && !wide) ? p2_sfr : addr[15:8]) : p2_sfr;
      chk(hi_out == ehi, ext ? "R7 hi_out" : "R8 hi_out", int'(hi_out), int'(ehi));
      chk(hi_oe == (ext ? 8'hFF : ~p2_sfr), ext ? "R7 hi_oe" : "R8 hi_oe", int'(hi_oe),
          int'(ext ? 8'hFF : ~p2_sfr));
      chk(rom_en == (intf && k == 0), "R3 rom_en", int'(rom_en), int'(intf && k == 0));
      if (intf && k == 0) chk(rom_addr == addr, "R3 rom_addr", int'(rom_addr), int'(addr));
      chk(req_ready == (k == 11), "R10 ready", int'(req_ready), int'(k == 11));
      if (k == 5 || k == 11) begin
        p0_sfr = 8'($urandom); p2_sfr = 8'($urandom);
      end
      @(negedge clk);
    end
    chk(rsp_valid == (isf || op == 2'd1), "R9 rsp_valid", int'(rsp_valid), int'(isf || op == 2'd1));
    if (isf || op == 2'd1)
      chk(rsp_data == (intf ? rom_fn(addr) : din), "R9 rsp_data", int'(rsp_data),
          int'(intf ? rom_fn(addr) : din));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 rsp one clock", int'(rsp_valid), 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D2C));
    rst_n = 1'b0; int_code_en = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_wide = 1'b0;
    req_addr = '0; req_wdata = '0; p0_sfr = 8'hFF; p2_sfr = 8'hFF; lo_in = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(psen_n && rd_n && wr_n, "R11 strobes in reset", int'({psen_n, rd_n, wr_n}), 7);
    chk(ale == 1'b1, "R11 phase 0 in reset", int'(ale), 1);
    chk(lo_oe == 8'h00 && rsp_valid == 1'b0, "R11 port released", int'(lo_oe), 0);
    rst_n = 1'b1;
    // R1 idle strobe rate
    for (int k = 0; k < 24; k++) begin
      chk(ale == ((k % 6) < 2), "R1 idle ale", int'(ale), int'((k % 6) < 2));
      chk(psen_n && rd_n && wr_n, "R5 idle strobes", int'({psen_n, rd_n, wr_n}), 7);
      @(negedge clk);
    end
    // directed corners
    run_op(2'd0, 1'b0, 16'h0010, 8'h00, 1'b0);  // R3 external when disabled
    run_op(2'd0, 1'b0, 16'h1FFF, 8'h00, 1'b1);  // R3 top internal
    run_op(2'd0, 1'b0, 16'h2000, 8'h00, 1'b1);  // R3 first external
    run_op(2'd0, 1'b0, 16'h0000, 8'h00, 1'b1);
    run_op(2'd1, 1'b1, 16'hA55A, 8'h00, 1'b1);  // R7 pointer read
    run_op(2'd1, 1'b0, 16'h3C81, 8'h00, 1'b1);  // R7 indirect read
    run_op(2'd2, 1'b1, 16'hBEEF, 8'hC3, 1'b0);  // R6 write
    run_op(2'd2, 1'b0, 16'h0042, 8'h18, 1'b0);
    run_op(2'd3, 1'b1, 16'hFFFF, 8'h77, 1'b0);  // R10 code 3 ignored
    for (int i = 0; i < 60; i++)
      run_op(2'($urandom), 1'($urandom), 16'($urandom), 8'($urandom), 1'($urandom));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule